// File: doc/BRIEF.md
# VBI Line Mode Dispatcher

This block sits between the line timing of a video decoder and the vertical-blanking data slicer. A bank of small per-line registers records which data service, if any, is carried on each line of the blanking interval. A global control register holds the sampling-rate choice, which is either square-pixel or BT.601. At every line start the block looks up the mode for the incoming line and pairs it with the sampling-rate bit. It then streams the matching configuration record out of an external configuration RAM, one byte per clock.

Each record is 15 bytes long, and records are placed on a 16-byte stride. The record index is twice the mode plus the sampling bit. Results returned by the slicer are steered according to the service class. Teletext bytes always go to an internal first-word-fall-through FIFO, and no other route is possible for them. Any other active service, such as closed caption or a custom code, goes to the FIFO, to a pair of caption registers, or to both. Two route bits select which.

Top module: `vbi_line_dispatch`

## Requirements
- R1: A write to address 0xD0+k stores bits [3:0] of the write data as the mode for line FIRST_LINE+k, for k from 0 to NUM_LINES-1. At the next line start for that line, `cur_mode` shows that value. Bits [7:4] are discarded.
- R2: A line below FIRST_LINE, a line at or above FIRST_LINE+NUM_LINES, and a line whose stored code is 0 are all treated as mode 0. For such a line, `cur_mode` is 0, `ram_rd` stays low and `res_ready` stays low, and any result offered is ignored.
- R3: Bit 7 of the control register at 0x0D is the sampling-rate bit: 0 means square-pixel and 1 means BT.601. It is captured at each line start and shown on `cur_rate`.
- R4: For a line with a non-zero mode, `ram_rd` is high for exactly 15 consecutive cycles, starting in the cycle after `line_start`. In cycle n, where n runs from 0 to 14, `ram_addr` equals (mode*2+rate)*16+n.
- R5: When the mode is 1 to 5 (teletext), every accepted result byte goes to the FIFO. The caption registers and `cc_valid` are not changed.
- R6: When the mode is 6 to 15, bit 1 of 0x0D sends accepted bytes to the FIFO and bit 0 of 0x0D sends them to the caption registers. Either bit, both bits or neither may be set.
- R7: For the caption registers, the first byte accepted in a line goes to `cc_data[7:0]` and the second goes to `cc_data[15:8]`. The second byte also sets `cc_valid`, and later bytes in that line are ignored. A `cc_rd` pulse clears `cc_valid`.
- R8: A FIFO-bound byte that arrives while the FIFO is full is dropped, and this sets `fifo_ovf`. The flag stays set until reset.
- R9: The FIFO returns bytes in arrival order, with the head byte shown on `fifo_data` whenever `fifo_empty` is low. A `fifo_rd` pulse pops the head byte.
- R10: After reset, `fifo_empty` is 1 and `cc_valid`, `fifo_ovf`, `ram_rd` and `res_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| line_start | input | 1 | One-cycle pulse at the start of a line |
| line_num | input | LINE_W | Number of the line that is starting |
| cur_mode | output | 4 | Mode latched for the current line |
| cur_rate | output | 1 | Sampling-rate bit latched for the current line |
| ram_rd | output | 1 | Configuration RAM read enable |
| ram_addr | output | ADDR_W | Configuration RAM byte address |
| res_valid | input | 1 | Slicer result byte valid |
| res_data | input | 8 | Slicer result byte |
| res_ready | output | 1 | Results are accepted on this line |
| fifo_rd | input | 1 | Pop the FIFO head |
| fifo_data | output | 8 | FIFO head byte |
| fifo_empty | output | 1 | FIFO holds no bytes |
| fifo_ovf | output | 1 | Sticky drop flag |
| cc_rd | input | 1 | Host acknowledge for the caption registers |
| cc_data | output | 16 | Caption byte pair |
| cc_valid | output | 1 | Caption pair is ready |

## Verification
The properties take it that a `line_start` never falls in the same cycle as an offered result, a register write or a `cc_rd`. They also take it that the slicer offers results only after the configuration fetch for the line has ended. The stimulus meets these conditions by separating every event with at least one idle clock. It also finishes each 15-byte fetch before it sends any result bytes, and it pulses `cc_rd` only between lines. The FIFO is popped only while `fifo_empty` is low, so the occupancy bound and the ordering checks rest on legal reads alone.

// File: rtl/vbi_line_dispatch.sv
module vbi_line_dispatch #(
  parameter int LINE_W     = 10,
  parameter int FIRST_LINE = 10,
  parameter int NUM_LINES  = 44,
  parameter int BANK_BASE  = 8'hD0,
  parameter int CTRL_ADDR  = 8'h0D,
  parameter int FIFO_DEPTH = 16,
  parameter int REC_LEN    = 15,
  parameter int REC_STRIDE = 16,
  localparam int STRIDE_W  = $clog2(REC_STRIDE),
  localparam int ADDR_W    = 5 + STRIDE_W,
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int FIFO_AW   = $clog2(FIFO_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  output logic [3:0]        cur_mode,
  output logic              cur_rate,
  output logic              ram_rd,
  output logic [ADDR_W-1:0] ram_addr,
  input  logic              res_valid,
  input  logic [7:0]        res_data,
  output logic              res_ready,
  input  logic              fifo_rd,
  output logic [7:0]        fifo_data,
  output logic              fifo_empty,
  output logic              fifo_ovf,
  input  logic              cc_rd,
  output logic [15:0]       cc_data,
  output logic              cc_valid
);

  logic [3:0] bank [NUM_LINES];
  logic rate_q, route_regs, route_fifo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_LINES; i++) bank[i] <= '0;
      rate_q     <= 1'b0;
      route_regs <= 1'b0;
      route_fifo <= 1'b0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (cfg_addr == 8'(BANK_BASE + i)) bank[i] <= cfg_wdata[3:0];
      if (cfg_addr == 8'(CTRL_ADDR)) begin
        rate_q     <= cfg_wdata[7];
        route_fifo <= cfg_wdata[1];
        route_regs <= cfg_wdata[0];
      end
    end
  end

  wire in_range = (line_num >= LINE_W'(FIRST_LINE)) &&
                  (line_num <  LINE_W'(FIRST_LINE + NUM_LINES));
  wire [LINE_W-1:0] rel = line_num - LINE_W'(FIRST_LINE);
  wire [IDX_W-1:0]  idx = rel[IDX_W-1:0];
  wire [3:0] sel_mode   = in_range ? bank[idx] : 4'd0;

  logic [3:0]          mode_q;
  logic                rate_l;
  logic                fetch_on;
  logic [STRIDE_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      rate_l   <= 1'b0;
      fetch_on <= 1'b0;
      cnt      <= '0;
    end else if (line_start) begin
      mode_q   <= sel_mode;
      rate_l   <= rate_q;
      fetch_on <= (sel_mode != 4'd0);
      cnt      <= '0;
    end else if (fetch_on) begin
      if (cnt == STRIDE_W'(REC_LEN - 1)) fetch_on <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign cur_mode  = mode_q;
  assign cur_rate  = rate_l;
  assign ram_rd    = fetch_on;
  assign ram_addr  = {mode_q, rate_l, cnt};
  assign res_ready = (mode_q != 4'd0);

  wire is_ttx  = (mode_q >= 4'd1) && (mode_q <= 4'd5);
  wire acc     = res_valid && res_ready;
  wire to_fifo = acc && (is_ttx || route_fifo);
  wire to_regs = acc && !is_ttx && route_regs;

  logic [7:0]         mem [FIFO_DEPTH];
  logic [FIFO_AW-1:0] wptr, rptr;
  logic [FIFO_AW:0]   fifo_cnt;
  wire full = (fifo_cnt == (FIFO_AW+1)'(FIFO_DEPTH));
  wire push = to_fifo && !full;
  wire pop  = fifo_rd && !fifo_empty;

  assign fifo_empty = (fifo_cnt == '0);
  assign fifo_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= res_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      fifo_cnt <= '0;
      fifo_ovf <= 1'b0;
    end else begin
      if (push) wptr <= (wptr == FIFO_AW'(FIFO_DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == FIFO_AW'(FIFO_DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      fifo_cnt <= fifo_cnt + 1'b1;
      else if (pop && !push) fifo_cnt <= fifo_cnt - 1'b1;
      if (to_fifo && full) fifo_ovf <= 1'b1;
    end
  end

  logic [1:0] cc_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_sel   <= '0;
      cc_data  <= '0;
      cc_valid <= 1'b0;
    end else begin
      if (line_start) cc_sel <= '0;
      else if (to_regs && cc_sel == 2'd0) begin
        cc_data[7:0] <= res_data;
        cc_sel       <= 2'd1;
      end else if (to_regs && cc_sel == 2'd1) begin
        cc_data[15:8] <= res_data;
        cc_sel        <= 2'd2;
      end
      if (!line_start && to_regs && cc_sel == 2'd1) cc_valid <= 1'b1;
      else if (cc_rd) cc_valid <= 1'b0;
    end
  end

endmodule

module vbi_line_dispatch_chk #(
  parameter int ADDR_W     = 9,
  parameter int STRIDE_W   = 4,
  parameter int REC_LEN    = 15,
  parameter int FIFO_DEPTH = 16,
  parameter int FIFO_AW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic [3:0]        cur_mode,
  input logic              ram_rd,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              res_ready,
  input logic              cc_valid,
  input logic              fifo_ovf,
  input logic [FIFO_AW:0]  fifo_cnt
);

  p_mode_zero_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 4'd0) |-> (!ram_rd && !res_ready));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && $past(ram_rd) && !$past(line_start)) |->
      (ram_addr[STRIDE_W-1:0] == $past(ram_addr[STRIDE_W-1:0]) + 1'b1));

  p_addr_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |-> (ram_addr[STRIDE_W-1:0] <= STRIDE_W'(REC_LEN - 1)));

  p_fetch_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_rd) |-> (ram_addr[STRIDE_W-1:0] == '0));

  p_ttx_no_regs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_valid) |-> !($past(cur_mode) inside {[4'd1:4'd5]}));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);

  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= (FIFO_AW+1)'(FIFO_DEPTH));

endmodule

bind vbi_line_dispatch vbi_line_dispatch_chk #(
  .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .REC_LEN(REC_LEN),
  .FIFO_DEPTH(FIFO_DEPTH), .FIFO_AW(FIFO_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .cur_mode(cur_mode),
  .ram_rd(ram_rd), .ram_addr(ram_addr), .res_ready(res_ready),
  .cc_valid(cc_valid), .fifo_ovf(fifo_ovf), .fifo_cnt(fifo_cnt)
);

// File: tb/sim_vbi_line_dispatch.sv
`timescale 1ns/1ps
module sim_vbi_line_dispatch;
  localparam int DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0, cfg_wdata = 0;
  logic line_start = 0; logic [9:0] line_num = 0;
  logic [3:0] cur_mode; logic cur_rate, ram_rd; logic [8:0] ram_addr;
  logic res_valid = 0; logic [7:0] res_data = 0; logic res_ready;
  logic fifo_rd = 0; logic [7:0] fifo_data; logic fifo_empty, fifo_ovf;
  logic cc_rd = 0; logic [15:0] cc_data; logic cc_valid;

  vbi_line_dispatch u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit drain = 1, done = 0;
  bit [7:0] q[$];
  bit route_f = 0, route_r = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && drain && !fifo_empty) begin
        if (q.size() == 0) chk(0, "R9 unexpected fifo byte", fifo_data, 0);
        else begin
          automatic bit [7:0] e = q.pop_front();
          chk(fifo_data == e, "R9 fifo order", fifo_data, e);
        end
        fifo_rd = 1;
      end else fifo_rd = 0;
    end
  end

  task automatic wr(input bit [7:0] a, input bit [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
    if (a == 8'h0D) begin route_f = d[1]; route_r = d[0]; end
  endtask

  task automatic do_line(input int ln, input int em, input bit er);
    @(negedge clk); line_start = 1; line_num = 10'(ln);
    @(negedge clk); line_start = 0;
    chk(cur_mode == 4'(em), "R1 R2 cur_mode", cur_mode, em);
    chk(res_ready == (em != 0), "R2 res_ready", res_ready, em != 0);
    if (em != 0) begin
      chk(cur_rate == er, "R3 cur_rate", cur_rate, er);
      for (int n = 0; n < 15; n++) begin
        chk(ram_rd && ram_addr == 9'((em*2 + er)*16 + n), "R4 fetch addr", ram_addr, (em*2 + er)*16 + n);
        @(negedge clk);
      end
    end
    chk(!ram_rd, "R4 R2 fetch off", ram_rd, 0);
  endtask

  task automatic send(input bit [7:0] d, input int em);
    @(negedge clk); res_valid = 1; res_data = d;
    if (em >= 1 && em <= 5) q.push_back(d);
    else if (em != 0 && route_f) q.push_back(d);
    @(negedge clk); res_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(fifo_empty && !cc_valid && !fifo_ovf && !ram_rd && !res_ready, "R10 reset state",
        {fifo_empty, cc_valid, fifo_ovf, ram_rd, res_ready}, 5'b10000);

    wr(8'hD0, 8'h03); wr(8'hFB, 8'h07); wr(8'hDA, 8'h06); wr(8'hE4, 8'h5F);
    wr(8'h0D, 8'h81);

    do_line(10, 3, 1);
    send(8'hA1, 3); send(8'hA2, 3); send(8'hA3, 3);
    repeat (6) @(negedge clk);
    chk(!cc_valid && cc_data == 16'h0, "R5 teletext leaves regs", cc_data, 0);

    do_line(53, 7, 1);
    send(8'h41, 7); send(8'h42, 7); send(8'h43, 7);
    @(negedge clk);
    chk(cc_valid && cc_data == 16'h4241, "R7 caption pair", cc_data, 16'h4241);
    chk(fifo_empty, "R6 regs-only route skips fifo", fifo_empty, 1);
    @(negedge clk); cc_rd = 1; @(negedge clk); cc_rd = 0;
    chk(!cc_valid, "R7 cc_rd clears valid", cc_valid, 0);

    wr(8'h0D, 8'h03);
    do_line(20, 6, 0);
    send(8'h11, 6); send(8'h22, 6);
    @(negedge clk);
    chk(cc_valid && cc_data == 16'h2211, "R6 both routes regs", cc_data, 16'h2211);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R6 both routes fifo", q.size(), 0);

    do_line(30, 15, 0);
    do_line(9, 0, 0);
    send(8'hEE, 0);
    do_line(54, 0, 0);
    send(8'hEF, 0);
    do_line(11, 0, 0);
    send(8'hF0, 0);
    repeat (3) @(negedge clk);
    chk(fifo_empty, "R2 ignored results", fifo_empty, 1);

    drain = 0;
    do_line(10, 3, 0);
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk); res_valid = 1; res_data = 8'(8'h60 + i);
      if (i < DEPTH) q.push_back(8'(8'h60 + i));
      @(negedge clk); res_valid = 0;
    end
    @(negedge clk);
    chk(fifo_ovf, "R8 overflow set", fifo_ovf, 1);
    drain = 1;
    repeat (2*DEPTH + 6) @(negedge clk);
    chk(q.size() == 0 && fifo_empty, "R8 R9 drained in order", q.size(), 0);
    chk(fifo_ovf, "R8 overflow sticky", fifo_ovf, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule